// File: doc/BRIEF.md
# Deferred Condition Code Evaluator

This unit holds the saved record of the last flag-setting operation and turns it into the four integer condition flags only when they are needed. A load strobe captures an operation-kind code together with two 32-bit words: the operation's result (dest) and its second operand (src). The first operand is never kept. When flags are required, the flush strobe evaluates the record. The first operand is rebuilt by undoing the operation, and carry and overflow are derived from the rebuilt value. After evaluation the record is rewritten as a pass-through record whose dest word carries the flags.

Nine kinds are understood: pass-through, logic, 32-bit add, 32-bit subtract, byte compare, word compare, add with extend, subtract with extend, and shift. If a flush finds any other code stored, the record and the flags are left alone and an error output is raised.

Top module: `cc_resolver`

## Requirements
- R1: After reset, flagsOut is 0, kindOut is 0 (pass-through), destOut is 0 and badKind is 0.
- R2: A load (loadStb high) stores kindIn, srcIn and destIn. From the next cycle kindOut and destOut show the stored kind and dest, badKind is 0, and flagsOut is unchanged.
- R3: Kind codes are 0 pass-through, 1 logic, 2 add, 3 subtract, 4 byte compare, 5 word compare, 6 add-with-extend, 7 subtract-with-extend, 8 shift. One cycle after a flush of a stored known kind, flagsOut holds {N,Z,V,C} in bits 3..0, kindOut is 0 and destOut equals the four flags zero-extended. Without a flush, flagsOut does not change.
- R4: For every kind except pass-through, Z is 1 when the result at the operation width is zero. N is 1 only when that result is nonzero and its top bit is 1.
- R5: For add and add-with-extend, C is the carry out of first operand plus src (plus 1 for the extend kind), and V is the signed overflow of that sum.
- R6: For subtract and subtract-with-extend, C is the borrow of first operand minus src (minus 1 for the extend kind), and V is the signed overflow of that difference.
- R7: Byte and word compare apply the subtract rule to bits 7..0 and 15..0 of src and dest. Bits above those widths have no effect on any flag.
- R8: For shift, C is 1 exactly when src is nonzero, and V is 0. For logic, V and C are both 0.
- R9: For pass-through, the flags become dest bits 3..0 unchanged.
- R10: A flush with a stored code of 9 to 15 sets badKind and leaves flagsOut, kindOut and destOut unchanged. badKind falls on the next load or valid flush.
- R11: When loadStb and flushStb are both high in one cycle, only the load takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| loadStb | input | 1 | Capture a new operation record |
| kindIn | input | 4 | Operation-kind code to capture |
| srcIn | input | 32 | Second operand (or shifted-out bit) to capture |
| destIn | input | 32 | Operation result to capture |
| flushStb | input | 1 | Evaluate the stored record into flags |
| flagsOut | output | 4 | Evaluated flags {N,Z,V,C} |
| kindOut | output | 4 | Currently stored kind code |
| destOut | output | 32 | Currently stored dest word |
| badKind | output | 1 | Last flush found an unknown code |

## Verification
A wrong stored kind or dest shows at kindOut and destOut one cycle after the load. A wrong evaluation shows at flagsOut one cycle after the flush. The same fault also shows at destOut, because the record is rewritten with the flags. Operands are drawn from corner values around zero, the sign boundary and all-ones at each operation width. Expected flags come from real carries and signed sums computed in the bench, so a fault in rebuilding the first operand changes C or V within one flush. Junk placed in the upper bits of the compare operands exposes any leak across the compare width.

// File: rtl/cc_resolver_pkg.sv
package cc_resolver_pkg;
  localparam int KIND_W = 4;
  localparam int FLAG_W = 4;
  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;

  typedef enum logic [KIND_W-1:0] {
    K_PASS  = 4'd0,
    K_LOGIC = 4'd1,
    K_ADD   = 4'd2,
    K_SUB   = 4'd3,
    K_CMPB  = 4'd4,
    K_CMPW  = 4'd5,
    K_ADDX  = 4'd6,
    K_SUBX  = 4'd7,
    K_SHIFT = 4'd8
  } kind_e;

  localparam logic [KIND_W-1:0] LAST_KIND = 4'd8;

  typedef struct packed {
    logic doLoad;
    logic doResolve;
    logic doReject;
  } ctrl_t;
endpackage

// File: rtl/cc_resolver_ctrl.sv
module cc_resolver_ctrl
  import cc_resolver_pkg::*;
(
  input  logic              loadStb,
  input  logic              flushStb,
  input  logic [KIND_W-1:0] kindQ,
  output ctrl_t             ctrl
);
  logic kindKnown;

  always_comb begin
    kindKnown      = (kindQ <= LAST_KIND);
    ctrl.doLoad    = loadStb;
    // load has priority over a flush in the same cycle (R11)
    ctrl.doResolve = flushStb && !loadStb && kindKnown;
    ctrl.doReject  = flushStb && !loadStb && !kindKnown;
  end
endmodule

// File: rtl/cc_resolver_dp.sv
module cc_resolver_dp
  import cc_resolver_pkg::*;
#(
  parameter int DATA_W = 32
)(
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic [KIND_W-1:0] kindIn,
  input  logic [DATA_W-1:0] srcIn,
  input  logic [DATA_W-1:0] destIn,
  output logic [KIND_W-1:0] kindQ,
  output logic [DATA_W-1:0] destQ,
  output logic [FLAG_W-1:0] flagsQ,
  output logic              badQ
);
  localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

  logic [DATA_W-1:0] srcQ;
  logic [FLAG_W-1:0] evalFlags;

  function automatic logic [DATA_W-1:0] widthMask(input int w);
    return ALL_ONES >> (DATA_W - w);
  endfunction

  // returns {N, Z}
  function automatic logic [1:0] nzAt(input logic [DATA_W-1:0] v, input int w);
    logic zero;
    zero = ((v & widthMask(w)) == '0);
    return {!zero && v[w-1], zero};
  endfunction

  // subtract family: minuend rebuilt as dest + src (+1 with extend)
  function automatic logic [FLAG_W-1:0] subAt(input logic [DATA_W-1:0] s,
                                               input logic [DATA_W-1:0] d,
                                               input int w, input logic xin);
    logic [DATA_W-1:0] minuend, m, ovf;
    logic cy;
    m       = widthMask(w);
    minuend = d + s + DATA_W'(xin);
    cy      = xin ? ((minuend & m) <= (s & m)) : ((minuend & m) < (s & m));
    ovf     = (minuend ^ d) & (minuend ^ s);
    return {nzAt(d, w), ovf[w-1], cy};
  endfunction

  // add family: first addend rebuilt as dest - src (-1 with extend)
  function automatic logic [FLAG_W-1:0] addAt(input logic [DATA_W-1:0] s,
                                               input logic [DATA_W-1:0] d,
                                               input logic xin);
    logic [DATA_W-1:0] addend, ovf;
    logic cy;
    addend = d - s - DATA_W'(xin);
    cy     = xin ? (d <= s) : (d < s);
    ovf    = (s ^ d) & ~(addend ^ s);
    return {nzAt(d, DATA_W), ovf[DATA_W-1], cy};
  endfunction

  always_comb begin
    case (kindQ)
      K_PASS:  evalFlags = destQ[FLAG_W-1:0];
      K_LOGIC: evalFlags = {nzAt(destQ, DATA_W), 2'b00};
      K_ADD:   evalFlags = addAt(srcQ, destQ, 1'b0);
      K_ADDX:  evalFlags = addAt(srcQ, destQ, 1'b1);
      K_SUB:   evalFlags = subAt(srcQ, destQ, DATA_W, 1'b0);
      K_SUBX:  evalFlags = subAt(srcQ, destQ, DATA_W, 1'b1);
      K_CMPB:  evalFlags = subAt(srcQ, destQ, BYTE_W, 1'b0);
      K_CMPW:  evalFlags = subAt(srcQ, destQ, HALF_W, 1'b0);
      K_SHIFT: evalFlags = {nzAt(destQ, DATA_W), 1'b0, (srcQ != '0)};
      default: evalFlags = flagsQ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kindQ  <= K_PASS;
      srcQ   <= '0;
      destQ  <= '0;
      flagsQ <= '0;
      badQ   <= 1'b0;
    end else if (ctrl.doLoad) begin
      kindQ <= kindIn;
      srcQ  <= srcIn;
      destQ <= destIn;
      badQ  <= 1'b0;
    end else if (ctrl.doResolve) begin
      kindQ  <= K_PASS;
      destQ  <= DATA_W'(evalFlags);
      flagsQ <= evalFlags;
      badQ   <= 1'b0;
    end else if (ctrl.doReject) begin
      badQ <= 1'b1;
    end
  end

  p_load_store_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.doLoad |=> kindQ == $past(kindIn) && destQ == $past(destIn) && $stable(flagsQ) && !badQ);

  p_resolve_record_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.doResolve |=> kindQ == K_PASS && destQ == DATA_W'(flagsQ));

  p_flags_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.doResolve |=> $stable(flagsQ));

  p_shift_carry_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.doResolve && kindQ == K_SHIFT) |=> flagsQ[0] == ($past(srcQ) != '0) && !flagsQ[1]);

  p_pass_copy_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.doResolve && kindQ == K_PASS) |=> flagsQ == $past(destQ[FLAG_W-1:0]));

  p_reject_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.doReject |=> badQ && $stable(kindQ) && $stable(destQ) && $stable(flagsQ));
endmodule

// File: rtl/cc_resolver.sv
module cc_resolver
  import cc_resolver_pkg::*;
#(
  parameter int DATA_W = 32
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadStb,
  input  logic [KIND_W-1:0] kindIn,
  input  logic [DATA_W-1:0] srcIn,
  input  logic [DATA_W-1:0] destIn,
  input  logic              flushStb,
  output logic [FLAG_W-1:0] flagsOut,
  output logic [KIND_W-1:0] kindOut,
  output logic [DATA_W-1:0] destOut,
  output logic              badKind
);
  ctrl_t ctrl;

  cc_resolver_ctrl u_ctrl (
    .loadStb  (loadStb),
    .flushStb (flushStb),
    .kindQ    (kindOut),
    .ctrl     (ctrl)
  );

  cc_resolver_dp #(.DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .kindIn (kindIn),
    .srcIn  (srcIn),
    .destIn (destIn),
    .kindQ  (kindOut),
    .destQ  (destOut),
    .flagsQ (flagsOut),
    .badQ   (badKind)
  );
endmodule

// File: tb/cc_resolver_test.sv
`timescale 1ns/1ps
module cc_resolver_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadStb = 1'b0;
  logic        flushStb = 1'b0;
  logic [3:0]  kindIn = '0;
  logic [31:0] srcIn = '0;
  logic [31:0] destIn = '0;
  logic [3:0]  flagsOut;
  logic [3:0]  kindOut;
  logic [31:0] destOut;
  logic        badKind;

  int nChk = 0;
  int nFail = 0;
  logic [3:0] lastFlags = 4'h0;

  always #5 clk = ~clk;

  cc_resolver uut (
    .clk(clk), .rstN(rstN), .loadStb(loadStb), .kindIn(kindIn), .srcIn(srcIn),
    .destIn(destIn), .flushStb(flushStb), .flagsOut(flagsOut), .kindOut(kindOut),
    .destOut(destOut), .badKind(badKind)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic longint maskW(input int w);
    return (longint'(1) << w) - 1;
  endfunction

  function automatic logic [31:0] corner(input int i, input int w);
    longint m = maskW(w);
    longint h = longint'(1) << (w - 1);
    longint v;
    case (i)
      0: v = 0;           1: v = 1;           2: v = 2;           3: v = h - 1;
      4: v = h;           5: v = h + 1;       6: v = m;           7: v = m - 1;
      8: v = 'h55555555;  9: v = 'hAAAAAAAA;  10: v = h - 2;      11: v = 3;
      12: v = 'h12345678; 13: v = 'h9ABCDEF0; 14: v = 'h0F0F0F0F; default: v = 'hF0F0F0F0;
    endcase
    return 32'(v & m);
  endfunction

  function automatic longint sx(input logic [31:0] v, input int w);
    longint s = longint'(v) & maskW(w);
    if (v[w-1]) s = s - (longint'(1) << w);
    return s;
  endfunction

  function automatic logic [1:0] nzExp(input logic [31:0] r, input int w);
    logic z = ((longint'(r) & maskW(w)) == 0);
    return {!z && r[w-1], z};
  endfunction

  // load, check record, flush, check flags
  task automatic runVec(input logic [3:0] k, input logic [31:0] s, input logic [31:0] d,
                        input logic [3:0] exp, input string req);
    @(negedge clk);
    loadStb = 1'b1; kindIn = k; srcIn = s; destIn = d;
    @(negedge clk);
    loadStb = 1'b0;
    chk(kindOut == k && destOut == d && flagsOut == lastFlags && !badKind, "R2 load", {kindOut, destOut[27:0]}, {k, d[27:0]});
    flushStb = 1'b1;
    @(negedge clk);
    flushStb = 1'b0;
    chk(flagsOut == exp, req, 32'(flagsOut), 32'(exp));
    chk(kindOut == 4'd0 && destOut == 32'(exp), "R3 record", destOut, 32'(exp));
    lastFlags = exp;
  endtask

  // arithmetic family: first operand a, second b, width w, extend x, subtract sb
  task automatic arithVec(input logic [3:0] k, input logic [31:0] a, input logic [31:0] b,
                          input int w, input bit x, input bit sb, input string req);
    longint ua = longint'(a) & maskW(w);
    longint ub = longint'(b) & maskW(w);
    longint sr, ur;
    logic [31:0] res, junk, d, s;
    logic c, v;
    if (sb) begin
      ur = ua - ub - x;
      c  = (ua < ub + x);
      sr = sx(a, w) - sx(b, w) - x;
    end else begin
      ur = ua + ub + x;
      c  = (ur > maskW(w));
      sr = sx(a, w) + sx(b, w) + x;
    end
    v    = (sr > maskW(w - 1)) || (sr < -(longint'(1) << (w - 1)));
    res  = 32'(ur & maskW(w));
    junk = (w < 32) ? (32'hC3A5_96E1 & ~32'(maskW(w))) : 32'h0;
    d    = res | junk;
    s    = b | (junk ^ (w < 32 ? 32'h7E00_0000 : 32'h0));
    runVec(k, s, d, {nzExp(res, w), v, c}, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(flagsOut == 4'h0 && kindOut == 4'h0 && destOut == 32'h0 && !badKind, "R1 reset", {flagsOut, kindOut, destOut[23:0]}, 32'h0);

    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        arithVec(4'd2, corner(i, 32), corner(j, 32), 32, 1'b0, 1'b0, "R5 R4 add");
        arithVec(4'd6, corner(i, 32), corner(j, 32), 32, 1'b1, 1'b0, "R5 R4 addx");
        arithVec(4'd3, corner(i, 32), corner(j, 32), 32, 1'b0, 1'b1, "R6 R4 sub");
        arithVec(4'd7, corner(i, 32), corner(j, 32), 32, 1'b1, 1'b1, "R6 R4 subx");
        arithVec(4'd4, corner(i, 8),  corner(j, 8),  8,  1'b0, 1'b1, "R7 byte compare");
        arithVec(4'd5, corner(i, 16), corner(j, 16), 16, 1'b0, 1'b1, "R7 word compare");
      end
    end

    for (int i = 0; i < 16; i++) begin
      logic [31:0] d = corner(i, 32);
      runVec(4'd1, corner(15 - i, 32), d, {nzExp(d, 32), 2'b00}, "R8 logic");
      runVec(4'd8, 32'h0, d, {nzExp(d, 32), 2'b00}, "R8 shift no carry");
      runVec(4'd8, 32'h1, d, {nzExp(d, 32), 2'b01}, "R8 shift carry");
      runVec(4'd8, 32'h8000_0000, d, {nzExp(d, 32), 2'b01}, "R8 shift carry high");
      runVec(4'd0, 32'hFFFF_FFFF, d ^ 32'(i), (d[3:0] ^ 4'(i)), "R9 pass");
    end

    for (int k = 9; k < 16; k++) begin
      @(negedge clk);
      loadStb = 1'b1; kindIn = 4'(k); srcIn = 32'h1; destIn = 32'hDEAD_0000 | 32'(k);
      @(negedge clk);
      loadStb = 1'b0; flushStb = 1'b1;
      @(negedge clk);
      flushStb = 1'b0;
      chk(badKind == 1'b1, "R10 bad raised", 32'(badKind), 32'h1);
      chk(flagsOut == lastFlags && kindOut == 4'(k) && destOut == (32'hDEAD_0000 | 32'(k)),
          "R10 state held", {flagsOut, kindOut, destOut[23:0]}, {lastFlags, 4'(k), 24'(k)});
    end
    runVec(4'd1, 32'h0, 32'h0, 4'b0100, "R10 bad cleared then R4 zero");

    // R11: load wins over a simultaneous flush
    @(negedge clk);
    loadStb = 1'b1; kindIn = 4'd2; srcIn = 32'h1; destIn = 32'h0;
    @(negedge clk);
    kindIn = 4'd1; destIn = 32'h8000_0000; flushStb = 1'b1;
    @(negedge clk);
    loadStb = 1'b0; flushStb = 1'b0;
    chk(kindOut == 4'd1 && destOut == 32'h8000_0000 && flagsOut == lastFlags, "R11 load wins",
        {flagsOut, kindOut, destOut[23:0]}, {lastFlags, 4'd1, 24'h0});
    flushStb = 1'b1;
    @(negedge clk);
    flushStb = 1'b0;
    chk(flagsOut == 4'b1000, "R11 later flush", 32'(flagsOut), 32'h8);
    repeat (2) @(negedge clk);
    chk(flagsOut == 4'b1000 && kindOut == 4'd0, "R3 flags hold without flush", 32'(flagsOut), 32'h8);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule